// File: doc/BRIEF.md
# Field-Configurable Sum-of-Products Logic Array

This block models a write-once AND/OR/invert logic array. It has sixteen inputs, forty-eight product terms and eight outputs. All configuration state is held as link bits. Every link starts intact after reset. A synchronous configuration port can only remove links. An attempt to put a removed link back has no effect and raises a one-cycle error flag.

Each product term has a true link and a complement link for every input. Removing both links makes that input a don't-care. Keeping both links inhibits the term. Each output ORs together the terms whose OR links are intact. A polarity link then either passes that sum through or inverts it.

The path from `din` and `ce_n` to the outputs is purely combinational. An active-low chip enable disables the outputs. A parameter selects the disabled behaviour: either the output enables drop (three-state style), or the data is forced to all ones with the enables held on (open-collector style).

Top module: `sop_array`

## Requirements
- R1: After reset every link is intact, so every product term is inhibited. With `ce_n` low, `out_data` is 8'h00 and `out_en` is 8'hFF.
- R2: In a product-term row, bit 2i is the true link and bit 2i+1 is the complement link of input i. A term is the AND of `din[i]` for each intact true link and `~din[i]` for each intact complement link. An input with both links removed does not affect the term.
- R3: If any input has both its true and complement links intact, the product term is 0 for every input vector.
- R4: Output o is the OR of every product term p whose OR link, bit p of output row o, is intact. A removed OR link contributes 0.
- R5: Polarity bit o set to 1 passes output o's sum unchanged. Polarity bit o cleared to 0 inverts it.
- R6: The configuration address map is as follows. Addresses 0 to 47 select product-term rows (32 data bits). Addresses 48 to 55 select the OR rows of outputs 0 to 7 (48 data bits). Address 56 selects the polarity row (8 data bits). All rows use the least significant bits of `cfg_data`. A write to any other address changes nothing and gives no error.
- R7: A write leaves the addressed row equal to its old value ANDed with the written data. Links can be removed but never restored.
- R8: `cfg_err` is 1 in the cycle after a write whose data has a 1 in a valid bit position where the addressed row already holds 0. After any other cycle it is 0.
- R9: With OPEN_DRAIN = 0, `out_en` is 8'h00 while `ce_n` is high and 8'hFF while `ce_n` is low. `out_data` always carries the logic value.
- R10: With OPEN_DRAIN = 1, `out_en` is always 8'hFF. `out_data` is 8'hFF while `ce_n` is high and the logic value while `ce_n` is low.
- R11: `out_data` and `out_en` follow changes on `din` and `ce_n` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores all links |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Row select: terms, OR rows, polarity |
| cfg_data | input | 48 | Link mask; a 0 removes a link |
| din | input | 16 | Logic inputs |
| ce_n | input | 1 | Active-low chip enable |
| out_data | output | 8 | Logic outputs |
| out_en | output | 8 | Per-output drive enable |
| cfg_err | output | 1 | Pulse after an attempt to restore a removed link |

## Verification
Directed vectors run against a single hand-built term (one true literal, one complement literal, fourteen don't-cares). Together they show that the true and complement links are mapped to the right bit positions and that don't-care inputs truly have no effect.

A term with one input holding both links is driven with both values of that input, which separates the inhibit rule from an ordinary literal. Polarity-only rows, where the sum is fixed at 0, show inversion apart from the OR mask.

Random configurations mix mostly don't-care literals, rare inhibits and half-populated OR masks. Applying random vectors with random chip enable to both the three-state and the open-collector variant at once exercises term hits, overlapping sums and the disabled forms together.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  parameter bit OPEN_DRAIN = 1'b0,
  parameter int ADDR_W = $clog2(N_TERM + N_OUT + 1),
  parameter int DATA_W = ((2*N_IN > N_TERM) ? 2*N_IN : N_TERM) > N_OUT ?
                         ((2*N_IN > N_TERM) ? 2*N_IN : N_TERM) : N_OUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [N_IN-1:0]   din,
  input  logic              ce_n,
  output logic [N_OUT-1:0]  out_data,
  output logic [N_OUT-1:0]  out_en,
  output logic              cfg_err
);

  localparam int LW       = 2 * N_IN;
  localparam int OR_BASE  = N_TERM;
  localparam int POL_ADDR = N_TERM + N_OUT;

  logic [LW-1:0]     and_q [N_TERM];
  logic [N_TERM-1:0] or_q  [N_OUT];
  logic [N_OUT-1:0]  pol_q;
  logic              err_q;
  logic              restore;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  f;

  // a write that would set a bit already cleared
  always_comb begin
    restore = 1'b0;
    for (int p = 0; p < N_TERM; p++)
      if (cfg_addr == ADDR_W'(p))
        restore = |(cfg_data[LW-1:0] & ~and_q[p]);
    for (int o = 0; o < N_OUT; o++)
      if (cfg_addr == ADDR_W'(OR_BASE + o))
        restore = |(cfg_data[N_TERM-1:0] & ~or_q[o]);
    if (cfg_addr == ADDR_W'(POL_ADDR))
      restore = |(cfg_data[N_OUT-1:0] & ~pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_TERM; p++) and_q[p] <= '1;
      for (int o = 0; o < N_OUT; o++)  or_q[o]  <= '1;
      pol_q <= '1;
      err_q <= 1'b0;
    end else begin
      err_q <= cfg_we & restore;
      if (cfg_we) begin
        for (int p = 0; p < N_TERM; p++)
          if (cfg_addr == ADDR_W'(p))
            and_q[p] <= and_q[p] & cfg_data[LW-1:0];
        for (int o = 0; o < N_OUT; o++)
          if (cfg_addr == ADDR_W'(OR_BASE + o))
            or_q[o] <= or_q[o] & cfg_data[N_TERM-1:0];
        if (cfg_addr == ADDR_W'(POL_ADDR))
          pol_q <= pol_q & cfg_data[N_OUT-1:0];
      end
    end
  end

  assign cfg_err = err_q;

  a_r8_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));

  a_r7_pol_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pol_q & ~$past(pol_q)) == '0));

  for (genvar p = 0; p < N_TERM; p++) begin : g_term
    logic [N_IN-1:0] lit;
    logic [N_IN-1:0] both;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit[i]  = (~and_q[p][2*i] | din[i]) & (~and_q[p][2*i+1] | ~din[i]);
      assign both[i] = and_q[p][2*i] & and_q[p][2*i+1];
    end
    assign term[p] = &lit;

    a_r3_pair_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
      (|both) |-> !term[p]);

    a_r7_and_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((and_q[p] & ~$past(and_q[p])) == '0));
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign f[o] = (|(term & or_q[o])) ^ ~pol_q[o];

    a_r7_or_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((or_q[o] & ~$past(or_q[o])) == '0));
  end

  if (OPEN_DRAIN) begin : g_od
    assign out_data = ce_n ? '1 : f;
    assign out_en   = '1;

    a_r10_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (out_data == '1));
    a_r10_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
      out_en == '1);
  end else begin : g_ts
    assign out_data = f;
    assign out_en   = ce_n ? '0 : '1;

    a_r9_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (out_en == '0));
    a_r9_on_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |-> (out_en == '1));
  end

endmodule

// File: tb/sim_sop_array.sv
module sim_sop_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [47:0] cfg_data = '0;
  logic [15:0] din = '0;
  logic        ce_n = 1'b0;
  logic [7:0]  d0, e0, d1, e1;
  logic        err0, err1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sop_array u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                .cfg_data(cfg_data), .din(din), .ce_n(ce_n),
                .out_data(d0), .out_en(e0), .cfg_err(err0));
  sop_array #(.OPEN_DRAIN(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
                .cfg_addr(cfg_addr), .cfg_data(cfg_data), .din(din), .ce_n(ce_n),
                .out_data(d1), .out_en(e1), .cfg_err(err1));

  logic [31:0] m_and [48];
  logic [47:0] m_or  [8];
  logic [7:0]  m_pol;

  typedef struct packed {
    logic [7:0]  f;
    logic        ce;
    logic [23:0] tag;
  } item_t;
  item_t sb[$];

  function automatic logic [7:0] model_f(input logic [15:0] x);
    logic [47:0] t;
    logic [7:0]  r;
    for (int p = 0; p < 48; p++) begin
      t[p] = 1'b1;
      for (int i = 0; i < 16; i++) begin
        if (m_and[p][2*i] && m_and[p][2*i+1]) t[p] = 1'b0;
        else if (m_and[p][2*i] && !x[i])      t[p] = 1'b0;
        else if (m_and[p][2*i+1] && x[i])     t[p] = 1'b0;
      end
    end
    for (int o = 0; o < 8; o++)
      r[o] = (|(t & m_or[o])) ? m_pol[o] : ~m_pol[o];
    return r;
  endfunction

  task automatic check(input logic [23:0] tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.ce) check(it.tag, "u0 enable off", {40'h0, e0}, 48'h0);
      else begin
        check(it.tag, "u0 data", {40'h0, d0}, {40'h0, it.f});
        check(it.tag, "u0 enable on", {40'h0, e0}, 48'hff);
      end
      check(it.tag, "u1 data", {40'h0, d1}, {40'h0, it.ce ? 8'hff : it.f});
      check(it.tag, "u1 enable", {40'h0, e1}, 48'hff);
    end
  end

  task automatic apply(input logic [15:0] x, input logic ce, input logic [23:0] tag);
    item_t it;
    @(posedge clk);
    #2;
    din = x;
    ce_n = ce;
    it.f = model_f(x);
    it.ce = ce;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(posedge clk);
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [47:0] d, input logic [23:0] tag);
    logic exp_err;
    drain();
    exp_err = 1'b0;
    if (a < 48) begin
      exp_err = |(d[31:0] & ~m_and[a]);
      m_and[a] = m_and[a] & d[31:0];
    end else if (a < 56) begin
      exp_err = |(d & ~m_or[a-48]);
      m_or[a-48] = m_or[a-48] & d;
    end else if (a == 56) begin
      exp_err = |(d[7:0] & ~m_pol);
      m_pol = m_pol & d[7:0];
    end
    @(posedge clk);
    #2;
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_data = d;
    @(posedge clk);
    #2;
    cfg_we = 1'b0;
    check(tag, "cfg_err u0", {47'h0, err0}, {47'h0, exp_err});
    check(tag, "cfg_err u1", {47'h0, err1}, {47'h0, exp_err});
  endtask

  task automatic do_reset();
    drain();
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    for (int p = 0; p < 48; p++) m_and[p] = '1;
    for (int o = 0; o < 8; o++)  m_or[o]  = '1;
    m_pol = '1;
    repeat (2) @(posedge clk);
    #5;
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] rand_row();
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin
      int s;
      s = $urandom % 64;
      if (s == 0)      r[2*i +: 2] = 2'b11;
      else if (s < 7)  r[2*i +: 2] = 2'b01;
      else if (s < 13) r[2*i +: 2] = 2'b10;
      else             r[2*i +: 2] = 2'b00;
    end
    return r;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1", "cfg_err after reset", {47'h0, err0}, 48'h0);
    apply(16'h0000, 1'b0, "R1");
    apply(16'hffff, 1'b0, "R1");
    apply(16'ha5c3, 1'b0, "R1");
    check("R1", "model reset output", {40'h0, model_f(16'h1234)}, 48'h0);

    // R2 / R4: term 0 = din[0] & ~din[1], routed to output 0 only
    cfg_write(6'd0, 48'h0000_0000_0009, "R2");
    cfg_write(6'd48, 48'h0000_0000_0001, "R4");
    for (int o = 1; o < 8; o++) cfg_write(6'(48 + o), ~48'h1, "R4");
    apply(16'h0001, 1'b0, "R2");
    apply(16'h0003, 1'b0, "R2");
    apply(16'h0000, 1'b0, "R2");
    apply(16'hfff1, 1'b0, "R2");
    apply(16'h8ac5, 1'b0, "R11");
    apply(16'h8ac7, 1'b0, "R11");

    // R5: invert outputs 1..7
    cfg_write(6'd56, 48'h0000_0000_0001, "R5");
    apply(16'h0000, 1'b0, "R5");
    apply(16'h0001, 1'b0, "R5");

    // R3: term 1 has input 5 with both links, on output 1
    cfg_write(6'd1, 48'h0000_0000_0c00, "R3");
    apply(16'h0020, 1'b0, "R3");
    apply(16'h0000, 1'b0, "R3");
    apply(16'hffdf, 1'b0, "R3");

    // R7 / R8: restore attempt ignored, clear-only write flags nothing
    cfg_write(6'd0, 48'hffff_ffff_ffff, "R8");
    apply(16'h0001, 1'b0, "R7");
    apply(16'h0003, 1'b0, "R7");
    cfg_write(6'd56, 48'h0000_0000_00ff, "R8");
    apply(16'h0000, 1'b0, "R7");
    cfg_write(6'd2, 48'h0, "R8");

    // R6: out-of-range addresses change nothing
    for (int a = 57; a < 64; a++) cfg_write(6'(a), 48'h0, "R6");
    apply(16'h0001, 1'b0, "R6");
    apply(16'h0002, 1'b0, "R6");

    // R9 / R10: chip enable
    apply(16'h0001, 1'b1, "R9");
    apply(16'h0000, 1'b1, "R10");
    apply(16'h0001, 1'b0, "R9");

    // random configurations
    for (int round = 0; round < 4; round++) begin
      do_reset();
      for (int p = 0; p < 48; p++) cfg_write(6'(p), {16'h0, rand_row()}, "R7");
      for (int o = 0; o < 8; o++)
        cfg_write(6'(48 + o), {$urandom, $urandom} & 48'hffff_ffff_ffff, "R4");
      cfg_write(6'd56, {40'h0, 8'($urandom)}, "R5");
      for (int v = 0; v < 300; v++)
        apply(16'($urandom), ($urandom % 4) == 0, "R4");
    end

    drain();
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule